// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the per-input redirection settings of an interrupt router, together with a small identification register, a fixed version word and an arbitration register. A host reaches it through two 32-bit bus locations. The first is a select register. The second is a data window onto whichever internal register the select value names. Each redirection entry is 64 bits wide and is reached as two 32-bit halves at consecutive internal indices.

An entry holds an interrupt vector, a delivery mode, a destination mode, an input polarity bit, a trigger mode, a mask bit and an 8-bit destination. Two bits of the low half belong to the hardware, not to the host: delivery status and remote IRR. The delivery engine sets and clears them through strobe inputs. Host writes to the low half keep those two bits unchanged.

After every host write to an entry, the block raises a one-cycle pulse that carries the entry number. Downstream logic uses it to refresh any message it has cached for that entry.

Top module: `irq_redir_regfile`

## Requirements
- R1: Bus offset 0x00 is the select register, 32 bits, readable and writable. Bus offset 0x10 is the data window. An access at any other offset writes nothing and produces no read response.
- R2: An access is taken only when `bus_size_i` equals 4 (bytes). Any other size is dropped: it writes nothing and produces no read response.
- R3: A window write at internal index 0x00 stores write-data bits 27:24 as the ID. A window read at index 0x00 or at index 0x02 returns the ID in bits 27:24 and zero in all other bits. A window write at index 0x02 has no effect.
- R4: A window read at internal index 0x01 returns 0x00170011. A write of zero there raises no flag. A write of any nonzero value there leaves the register unchanged and pulses `inv_write_o` high for one cycle, one cycle after the write.
- R5: Entry n (0..23) sits at internal index 0x10+2n for its low half (bits 31:0) and at 0x11+2n for its high half (bits 63:32). The last valid index is 0x3F. Internal indices are decoded from select bits 7:0.
- R6: A low-half write stores every bit of the write data except bit 12 (delivery status) and bit 14 (remote IRR), which keep their current values.
- R7: A high-half write replaces bits 63:32 of the entry. The low half is left unchanged.
- R8: After reset, every entry's low half reads 0x00010000 (only the mask, bit 16, set), every high half reads 0, and the ID and select registers read 0.
- R9: A window read at an unmapped internal index (0x03..0x0F, 0x40..0xFF) returns zero. A write there changes no register and raises no update pulse.
- R10: One cycle after any window write to an entry half, `upd_valid_o` is high for one cycle and `upd_idx_o` carries that entry's number.
- R11: The status strobes act on the entry named by `sts_idx_i`. A set strobe makes the bit 1 and a clear strobe makes it 0. When set and clear arrive in the same cycle, set wins. The change is visible one cycle after the strobe.
- R12: An accepted read returns `bus_rvalid_o` high, with its data on `bus_rdata_o`, exactly one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_off_i | input | 8 | Bus offset |
| bus_size_i | input | 3 | Access size in bytes |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| sts_idx_i | input | 5 | Entry number for the status strobes |
| sts_dlv_set_i | input | 1 | Set delivery status |
| sts_dlv_clr_i | input | 1 | Clear delivery status |
| sts_rirr_set_i | input | 1 | Set remote IRR |
| sts_rirr_clr_i | input | 1 | Clear remote IRR |
| upd_valid_o | output | 1 | Entry updated pulse |
| upd_idx_o | output | 5 | Entry number of the update |
| inv_write_o | output | 1 | Nonzero write to the version register |

## Verification
The bench sweeps every entry half with its own data pattern and also reads every unmapped internal index. A decoder that is off by one in the entry mapping shows up as a wrong readback or a wrong update number. A decoder that lets index 0x40 alias into the table returns nonzero data where zero is expected.

The low-half write is run with the hardware status bits already set. A design that lets host data overwrite bits 12 or 14 loses them on readback. The same entry gets a high-half write after its low half is written. A design that clobbers the other half fails that readback.

Bad sizes, bad offsets and nonzero version writes are each checked for leaving the select, ID and version state intact. A design that decodes only the offset would take a dropped access and change the select register.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [31:0] VERSION_WORD = 32'h0017_0011;
  localparam logic [31:0] LO_RESET     = 32'h0001_0000;
  localparam int DLV_BIT  = 12;
  localparam int RIRR_BIT = 14;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENTRY
  } tgt_e;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int IDX_W       = 5,
  parameter logic [7:0] WIN_BASE = 8'h10
) (
  input  logic [7:0]       sel_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  localparam int SPAN = 2 * NUM_ENTRIES;

  logic [8:0] rel;
  logic       in_tbl;

  // WIN_BASE is even, so rel[0] picks the half
  assign rel    = {1'b0, sel_i} - {1'b0, WIN_BASE};
  assign in_tbl = (rel < 9'(SPAN));
  assign hi_o   = rel[0];
  assign idx_o  = in_tbl ? IDX_W'(rel >> 1) : '0;

  always_comb begin
    unique case (sel_i)
      8'h00:   tgt_o = TGT_ID;
      8'h01:   tgt_o = TGT_VER;
      8'h02:   tgt_o = TGT_ARB;
      default: tgt_o = in_tbl ? TGT_ENTRY : TGT_NONE;
    endcase
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        dlv_set_i,
  input  logic        dlv_clr_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o
);
  logic [31:0] lo_q, hi_q;
  logic [31:0] lo_nxt;

  always_comb begin
    lo_nxt = lo_q;
    if (wr_lo_i) begin
      lo_nxt = wdata_i;
      lo_nxt[DLV_BIT]  = lo_q[DLV_BIT];
      lo_nxt[RIRR_BIT] = lo_q[RIRR_BIT];
    end
    if (dlv_set_i)       lo_nxt[DLV_BIT] = 1'b1;
    else if (dlv_clr_i)  lo_nxt[DLV_BIT] = 1'b0;
    if (rirr_set_i)      lo_nxt[RIRR_BIT] = 1'b1;
    else if (rirr_clr_i) lo_nxt[RIRR_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= LO_RESET;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nxt;
      if (wr_hi_i) hi_q <= wdata_i;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int ID_W        = 4,
  parameter int ID_LSB      = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_off_i,
  input  logic [2:0]       bus_size_i,
  input  logic [31:0]      bus_wdata_i,
  output logic             bus_rvalid_o,
  output logic [31:0]      bus_rdata_o,
  input  logic [IDX_W-1:0] sts_idx_i,
  input  logic             sts_dlv_set_i,
  input  logic             sts_dlv_clr_i,
  input  logic             sts_rirr_set_i,
  input  logic             sts_rirr_clr_i,
  output logic             upd_valid_o,
  output logic [IDX_W-1:0] upd_idx_o,
  output logic             inv_write_o
);
  localparam logic [7:0] SEL_OFF = 8'h00;
  localparam logic [7:0] WIN_OFF = 8'h10;
  localparam logic [2:0] WORD_SZ = 3'd4;

  logic              acc, sel_hit, win_hit;
  logic              sel_wr, win_wr, rd_acc;
  logic [31:0]       sel_q;
  logic [ID_W-1:0]   id_q;
  tgt_e              tgt;
  logic [IDX_W-1:0]  ent_idx;
  logic              ent_hi;
  logic [31:0]       lo_arr [NUM_ENTRIES];
  logic [31:0]       hi_arr [NUM_ENTRIES];
  logic [31:0]       ent_word, win_word, rd_word;

  assign acc     = bus_req_i && (bus_size_i == WORD_SZ);
  assign sel_hit = (bus_off_i == SEL_OFF);
  assign win_hit = (bus_off_i == WIN_OFF);
  assign sel_wr  = acc && bus_we_i && sel_hit;
  assign win_wr  = acc && bus_we_i && win_hit;
  assign rd_acc  = acc && !bus_we_i && (sel_hit || win_hit);

  irq_redir_decode #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W),
    .WIN_BASE   (8'h10)
  ) u_dec (
    .sel_i(sel_q[7:0]),
    .tgt_o(tgt),
    .idx_o(ent_idx),
    .hi_o (ent_hi)
  );

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    logic hit, sts_hit;
    assign hit     = win_wr && (tgt == TGT_ENTRY) && (ent_idx == IDX_W'(n));
    assign sts_hit = (sts_idx_i == IDX_W'(n));
    irq_redir_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (hit && !ent_hi),
      .wr_hi_i   (hit && ent_hi),
      .wdata_i   (bus_wdata_i),
      .dlv_set_i (sts_hit && sts_dlv_set_i),
      .dlv_clr_i (sts_hit && sts_dlv_clr_i),
      .rirr_set_i(sts_hit && sts_rirr_set_i),
      .rirr_clr_i(sts_hit && sts_rirr_clr_i),
      .lo_o      (lo_arr[n]),
      .hi_o      (hi_arr[n])
    );
  end

  always_comb begin
    ent_word = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ent_idx == IDX_W'(i)) ent_word = ent_hi ? hi_arr[i] : lo_arr[i];
    end
  end

  always_comb begin
    win_word = '0;
    case (tgt)
      TGT_ID, TGT_ARB: win_word[ID_LSB +: ID_W] = id_q;
      TGT_VER:         win_word = VERSION_WORD;
      TGT_ENTRY:       win_word = ent_word;
      default:         win_word = '0;
    endcase
  end

  assign rd_word = sel_hit ? sel_q : win_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q        <= '0;
      id_q         <= '0;
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
      upd_valid_o  <= 1'b0;
      upd_idx_o    <= '0;
      inv_write_o  <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata_i;
      if (win_wr && tgt == TGT_ID) id_q <= bus_wdata_i[ID_LSB +: ID_W];
      bus_rvalid_o <= rd_acc;
      if (rd_acc) bus_rdata_o <= rd_word;
      upd_valid_o  <= win_wr && (tgt == TGT_ENTRY);
      if (win_wr && tgt == TGT_ENTRY) upd_idx_o <= ent_idx;
      inv_write_o  <= win_wr && (tgt == TGT_VER) && (bus_wdata_i != '0);
    end
  end
endmodule

// File: rtl/irq_redir_regfile_chk.sv
module irq_redir_regfile_chk #(
  parameter int NUM_ENTRIES = 24,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [7:0]       bus_off_i,
  input logic [2:0]       bus_size_i,
  input logic [31:0]      bus_wdata_i,
  input logic             bus_rvalid_o,
  input logic [31:0]      bus_rdata_o,
  input logic [IDX_W-1:0] sts_idx_i,
  input logic             sts_dlv_set_i,
  input logic             sts_dlv_clr_i,
  input logic             sts_rirr_set_i,
  input logic             sts_rirr_clr_i,
  input logic             upd_valid_o,
  input logic [IDX_W-1:0] upd_idx_o,
  input logic             inv_write_o
);
  AST_RVALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_req_i && !bus_we_i &&
                           (bus_off_i == 8'h00 || bus_off_i == 8'h10))); // R1
  AST_BAD_SIZE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_size_i != 3'd4) |=> !bus_rvalid_o); // R2
  AST_INV_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_write_o |-> $past(bus_req_i && bus_we_i && bus_off_i == 8'h10 &&
                          bus_wdata_i != 32'h0)); // R4
  AST_UPD_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_idx_o < IDX_W'(NUM_ENTRIES))); // R5
  AST_UPD_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(bus_req_i && bus_we_i && bus_off_i == 8'h10 &&
                          bus_size_i == 3'd4)); // R10
  AST_UPD_NOT_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_valid_o && inv_write_o)); // R9
  AST_READ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_size_i == 3'd4 && bus_off_i == 8'h10)
      |=> bus_rvalid_o); // R12
endmodule

bind irq_redir_regfile irq_redir_regfile_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .IDX_W      (IDX_W)
) u_chk (.*);

// File: tb/irq_redir_regfile_bench.sv
module irq_redir_regfile_bench;
  localparam int N = 24;
  localparam int IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [7:0] off = 0;
  logic [2:0] sz = 4;
  logic [31:0] wd = 0;
  logic rvalid;
  logic [31:0] rdata;
  logic [IW-1:0] sidx = 0;
  logic dset = 0, dclr = 0, rset = 0, rclr = 0;
  logic upd_v, inv_w;
  logic [IW-1:0] upd_i;

  int n_chk = 0, n_fail = 0;
  logic s_upd, s_inv;
  logic [IW-1:0] s_idx;

  always #5 clk = ~clk;

  irq_redir_regfile u_irq_redir_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_off_i(off), .bus_size_i(sz),
    .bus_wdata_i(wd), .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .sts_idx_i(sidx), .sts_dlv_set_i(dset), .sts_dlv_clr_i(dclr),
    .sts_rirr_set_i(rset), .sts_rirr_clr_i(rclr),
    .upd_valid_o(upd_v), .upd_idx_o(upd_i), .inv_write_o(inv_w)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] o, input logic [31:0] d, input logic [2:0] s = 3'd4);
    @(negedge clk); req = 1; we = 1; off = o; wd = d; sz = s;
    @(negedge clk); req = 0; we = 0; sz = 4;
    s_upd = upd_v; s_idx = upd_i; s_inv = inv_w;
  endtask

  task automatic brd(input logic [7:0] o, output logic v, output logic [31:0] d,
                     input logic [2:0] s = 3'd4);
    @(negedge clk); req = 1; we = 0; off = o; sz = s;
    @(negedge clk); v = rvalid; d = rdata; req = 0; sz = 4;
  endtask

  task automatic wwin(input logic [7:0] ix, input logic [31:0] d);
    bwr(8'h00, {24'h0, ix});
    bwr(8'h10, d);
  endtask

  task automatic rwin(input logic [7:0] ix, output logic [31:0] d);
    logic v;
    bwr(8'h00, {24'h0, ix});
    brd(8'h10, v, d);
    chk("R12 rvalid", {31'h0, v}, 32'h1);
  endtask

  task automatic strobe(input int ix, input logic a, input logic b, input logic c, input logic e);
    @(negedge clk); sidx = IW'(ix); dset = a; dclr = b; rset = c; rclr = e;
    @(negedge clk); dset = 0; dclr = 0; rset = 0; rclr = 0;
  endtask

  function automatic logic [31:0] lo_pat(input int k);
    return 32'hC3A0_0000 ^ (32'(k) * 32'h0001_0B17) ^ 32'h0000_5000;
  endfunction
  function automatic logic [31:0] hi_pat(input int k);
    return {8'(k * 11 + 1), 24'h5A_0000 ^ 24'(k)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8 reset state
    brd(8'h00, v, d);
    chk("R8 select reset", d, 32'h0);
    chk("R12 select rvalid", {31'h0, v}, 32'h1);
    for (int k = 0; k < N; k++) begin
      rwin(8'(16 + 2 * k), d); chk("R8 low reset", d, 32'h0001_0000);
      rwin(8'(17 + 2 * k), d); chk("R8 high reset", d, 32'h0);
    end
    rwin(8'h00, d); chk("R8 id reset", d, 32'h0);

    // R4 version
    rwin(8'h01, d); chk("R4 version", d, 32'h0017_0011);
    bwr(8'h10, 32'h0);
    chk("R4 zero write no flag", {31'h0, s_inv}, 32'h0);
    bwr(8'h10, 32'h0000_1234);
    chk("R4 nonzero flag", {31'h0, s_inv}, 32'h1);
    brd(8'h10, v, d); chk("R4 version kept", d, 32'h0017_0011);

    // R3 id and arbitration
    wwin(8'h00, 32'hFA00_0000);
    rwin(8'h00, d); chk("R3 id", d, 32'h0A00_0000);
    rwin(8'h02, d); chk("R3 arb", d, 32'h0A00_0000);
    wwin(8'h02, 32'h0500_0000);
    rwin(8'h00, d); chk("R3 arb write ignored", d, 32'h0A00_0000);

    // R5 R6 R7 R10 entry sweep
    for (int k = 0; k < N; k++) begin
      wwin(8'(16 + 2 * k), lo_pat(k));
      chk("R10 upd lo", {31'h0, s_upd}, 32'h1);
      chk("R10 idx lo", 32'(s_idx), 32'(k));
      wwin(8'(17 + 2 * k), hi_pat(k));
      chk("R10 upd hi", {31'h0, s_upd}, 32'h1);
      chk("R10 idx hi", 32'(s_idx), 32'(k));
    end
    for (int k = 0; k < N; k++) begin
      rwin(8'(16 + 2 * k), d); chk("R6 R7 low", d, lo_pat(k) & ~32'h0000_5000);
      rwin(8'(17 + 2 * k), d); chk("R5 high", d, hi_pat(k));
    end

    // R11 status strobes, R6 preservation
    strobe(3, 1, 0, 1, 0);
    rwin(8'h16, d); chk("R11 set both", d, (lo_pat(3) & ~32'h5000) | 32'h5000);
    wwin(8'h16, 32'h0000_0A21);
    rwin(8'h16, d); chk("R6 status kept", d, 32'h0000_5A21);
    strobe(3, 1, 1, 0, 1);
    rwin(8'h16, d); chk("R11 set wins, rirr clr", d, 32'h0000_1A21);
    strobe(3, 0, 1, 0, 0);
    rwin(8'h16, d); chk("R11 dlv clr", d, 32'h0000_0A21);
    wwin(8'h16, 32'hFFFF_FFFF);
    rwin(8'h16, d); chk("R6 ones keep zeros", d, 32'hFFFF_AFFF);
    rwin(8'h17, d); chk("R7 high kept", d, hi_pat(3));

    // R9 unmapped
    for (int ix = 3; ix < 256; ix++) begin
      if (ix < 16 || ix >= 16 + 2 * N) begin
        rwin(8'(ix), d); chk("R9 unmapped read", d, 32'h0);
      end
    end
    wwin(8'h05, 32'hFFFF_FFFF);
    chk("R9 no upd", {31'h0, s_upd}, 32'h0);
    wwin(8'h40, 32'hFFFF_FFFF);
    chk("R9 no upd top", {31'h0, s_upd}, 32'h0);
    rwin(8'h10, d); chk("R9 entry0 kept", d, lo_pat(0) & ~32'h5000);
    rwin(8'h3F, d); chk("R9 last kept", d, hi_pat(23));
    rwin(8'h00, d); chk("R9 id kept", d, 32'h0A00_0000);

    // R1 bad offsets
    bwr(8'h00, 32'h0000_0011);
    bwr(8'h04, 32'h0000_0022);
    brd(8'h00, v, d); chk("R1 bad offset write", d, 32'h0000_0011);
    brd(8'h20, v, d); chk("R1 bad offset read", {31'h0, v}, 32'h0);
    brd(8'h14, v, d); chk("R1 bad offset read2", {31'h0, v}, 32'h0);

    // R2 bad sizes
    bwr(8'h00, 32'h0000_0030, 3'd2);
    brd(8'h00, v, d); chk("R2 size write dropped", d, 32'h0000_0011);
    brd(8'h10, v, d, 3'd1); chk("R2 size read dropped", {31'h0, v}, 32'h0);
    bwr(8'h10, 32'h1234_5678, 3'd0);
    chk("R2 no upd", {31'h0, s_upd}, 32'h0);
    rwin(8'h11, d); chk("R2 entry kept", d, hi_pat(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule